// File: doc/BRIEF.md
# Dual-Channel Serial Transmit FIFO

This block buffers outgoing samples for a serial transmitter that carries a primary channel and, optionally, a secondary channel. A bus master writes data words into a write-only data register. The serializer asks for one frame at a time and receives a primary word and, when the secondary channel is on, a secondary word. Both channels share one array of 16-bit slots. A word of 16 bits or less takes one slot. A longer word takes two slots, the upper half first.

Two configuration inputs set the packing: the word-length select and the secondary enable. Any change to either one empties the buffer, so data packed under one setting is never read back under another. The block reports fill level, full and empty. It returns a bus error when the data register is read. It keeps sticky flags for a write of the wrong size, for an overflow and for an underflow. The sticky flags clear only on reset.

Top module: `dual_tx_buffer`

## Requirements
- R1: With long_word_i=0, each accepted write takes one slot. Eight writes fill the default 8-slot array, and full_o is then 1.
- R2: With long_word_i=1, each accepted write takes two slots. Four writes fill the array, and full_o is then 1. full_o is 1 whenever the free slots are fewer than one word needs. level_o counts occupied slots, and empty_o is 1 exactly when level_o is 0.
- R3: With sec_en_i=0, a frame request pops one word in arrival order. In short mode pri_data_o is the word zero-extended from bits [15:0]. sec_data_o is 0. frame_valid_o is 1 for the cycle after the accepting edge.
- R4: With sec_en_i=1, each frame pops two words. The first word written goes to pri_data_o and the next to sec_data_o, so written words alternate primary, secondary.
- R5: In long mode a 32-bit write stores bits [31:16] in the first slot and bits [15:0] in the second. A frame rebuilds each word exactly. A frame removes 2 slots, or 4 slots with the secondary channel on.
- R6: A read request (bus_req_i=1, bus_we_i=0) drives bus_err_o to 1 in the following cycle and leaves level_o and the stored data unchanged.
- R7: A write whose bus_size32_i differs from long_word_i sets size_err_o and keeps it set until reset. The write is discarded.
- R8: A correctly sized write with too little room for the whole word sets overflow_o and keeps it set until reset. The write is discarded, and the stored data and level stay unchanged.
- R9: A frame request with fewer occupied slots than one frame needs sets underflow_o and keeps it set until reset. Nothing is popped, and frame_valid_o stays 0.
- R10: A change on long_word_i or sec_en_i empties the buffer at the next clock edge. Any write or frame request in that cycle is discarded without setting a flag.
- R11: After reset level_o is 0, empty_o is 1, and full_o, bus_err_o, size_err_o, overflow_o, underflow_o and frame_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_word_i | input | 1 | 1: word length above 16 bits (two slots per word) |
| sec_en_i | input | 1 | Secondary channel enable |
| bus_req_i | input | 1 | Data register access request |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_size32_i | input | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| bus_wdata_i | input | 32 | Write data |
| bus_err_o | output | 1 | Bus error for a read, one cycle after the request |
| frame_req_i | input | 1 | Serializer asks for the next frame |
| frame_valid_o | output | 1 | Frame words updated this cycle |
| pri_data_o | output | 32 | Primary word of the frame |
| sec_data_o | output | 32 | Secondary word of the frame |
| level_o | output | LVL_W | Occupied slots |
| full_o | output | 1 | No room for one more word |
| empty_o | output | 1 | No slots occupied |
| size_err_o | output | 1 | Sticky: write size mismatch |
| overflow_o | output | 1 | Sticky: write dropped for lack of room |
| underflow_o | output | 1 | Sticky: frame request with too few entries |

## Verification
The bench runs all four combinations of word length and secondary enable. In each one it fills the buffer to capacity, then drains it and compares every primary and secondary word against a model queue. A design that swapped the two halves of a long word, or the primary and secondary order, would return mismatched words. A design that sized the array wrongly would report full_o or overflow at the wrong count. The bench also tries one write past capacity, a wrong-size write and a read at full. A design that dropped these writes late or only partly would change the level or shift the data drained next. Finally it sends frame requests with an empty buffer and with half a frame present, and it changes the configuration with data stored. A design that popped a partial frame or kept stale slots would leave a level other than the one expected.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  typedef struct packed {
    logic long_word;
    logic sec_en;
  } dtb_cfg_t;
endpackage

// File: rtl/dtb_storage.sv
module dtb_storage #(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 8,
  parameter int PTR_W  = $clog2(SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     we_two_i,
  input  logic [PTR_W-1:0]         wr_ptr_i,
  input  logic [SLOT_W-1:0]        wr_first_i,
  input  logic [SLOT_W-1:0]        wr_second_i,
  input  logic [PTR_W-1:0]         rd_ptr_i,
  output logic [3:0][SLOT_W-1:0]   rd_slot_o
);
  logic [SLOT_W-1:0] mem_q [SLOTS];
  logic [PTR_W-1:0]  wr_ptr_nx;

  assign wr_ptr_nx = wr_ptr_i + PTR_W'(1);

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[e] <= '0;
      end else if (we_i) begin
        if (wr_ptr_i == PTR_W'(e))                   mem_q[e] <= wr_first_i;
        else if (we_two_i && wr_ptr_nx == PTR_W'(e)) mem_q[e] <= wr_second_i;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_rd
    logic [PTR_W-1:0] idx;
    assign idx          = rd_ptr_i + PTR_W'(k);
    assign rd_slot_o[k] = mem_q[idx];
  end
endmodule

// File: rtl/dtb_ctrl.sv
module dtb_ctrl
  import dtb_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int PTR_W = $clog2(SLOTS),
  parameter int LVL_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dtb_cfg_t         cfg_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_size32_i,
  input  logic             frame_req_i,
  output logic             wr_en_o,
  output logic             wr_two_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             pop_en_o,
  output logic             flush_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             bus_err_o,
  output logic             size_err_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam logic [LVL_W:0] CAP = (LVL_W+1)'(SLOTS);

  dtb_cfg_t        cfg_q;
  logic [LVL_W-1:0] level_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W:0]   wneed, fneed, lvl_ext, lvl_nx;
  logic             wr_try, size_bad, room, pop_try;

  assign flush_o  = (cfg_i != cfg_q);
  assign wneed    = cfg_i.long_word ? (LVL_W+1)'(2) : (LVL_W+1)'(1);
  assign fneed    = cfg_i.sec_en ? (wneed << 1) : wneed;
  assign lvl_ext  = {1'b0, level_q};

  assign wr_try   = bus_req_i && bus_we_i && !flush_o;
  assign size_bad = wr_try && (bus_size32_i != cfg_i.long_word);
  assign room     = (lvl_ext + wneed) <= CAP;
  assign wr_en_o  = wr_try && !size_bad && room;
  assign wr_two_o = cfg_i.long_word;

  assign pop_try  = frame_req_i && !flush_o;
  assign pop_en_o = pop_try && (lvl_ext >= fneed);

  always_comb begin
    lvl_nx = lvl_ext;
    if (wr_en_o)  lvl_nx = lvl_nx + wneed;
    if (pop_en_o) lvl_nx = lvl_nx - fneed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      level_q     <= '0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      bus_err_o   <= 1'b0;
      size_err_o  <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      cfg_q     <= cfg_i;
      bus_err_o <= bus_req_i && !bus_we_i;
      if (size_bad)                          size_err_o  <= 1'b1;
      if (wr_try && !size_bad && !room)      overflow_o  <= 1'b1;
      if (pop_try && !pop_en_o)              underflow_o <= 1'b1;
      if (flush_o) begin
        level_q  <= '0;
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        level_q <= lvl_nx[LVL_W-1:0];
        if (wr_en_o)  wr_ptr_q <= wr_ptr_q + PTR_W'(wneed);
        if (pop_en_o) rd_ptr_q <= rd_ptr_q + PTR_W'(fneed);
      end
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign level_o  = level_q;
  assign full_o   = (lvl_ext + wneed) > CAP;
  assign empty_o  = (level_q == '0);
endmodule

// File: rtl/dtb_unpack.sv
module dtb_unpack
  import dtb_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pop_en_i,
  input  dtb_cfg_t               cfg_i,
  input  logic [3:0][SLOT_W-1:0] slot_i,
  output logic                   frame_valid_o,
  output logic [2*SLOT_W-1:0]    pri_o,
  output logic [2*SLOT_W-1:0]    sec_o
);
  logic [2*SLOT_W-1:0] pri_d, sec_d;

  always_comb begin
    if (cfg_i.long_word) begin
      pri_d = {slot_i[0], slot_i[1]};
      sec_d = {slot_i[2], slot_i[3]};
    end else begin
      pri_d = {{SLOT_W{1'b0}}, slot_i[0]};
      sec_d = {{SLOT_W{1'b0}}, slot_i[1]};
    end
    if (!cfg_i.sec_en) sec_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_valid_o <= 1'b0;
      pri_o         <= '0;
      sec_o         <= '0;
    end else begin
      frame_valid_o <= pop_en_i;
      if (pop_en_i) begin
        pri_o <= pri_d;
        sec_o <= sec_d;
      end
    end
  end
endmodule

// File: rtl/dual_tx_buffer.sv
module dual_tx_buffer
  import dtb_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 8,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int LVL_W = $clog2(SLOTS + 1),
  localparam int BUS_W = 2 * SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             long_word_i,
  input  logic             sec_en_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_size32_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic             bus_err_o,
  input  logic             frame_req_i,
  output logic             frame_valid_o,
  output logic [BUS_W-1:0] pri_data_o,
  output logic [BUS_W-1:0] sec_data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             size_err_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  dtb_cfg_t              cfg;
  logic                  wr_en, wr_two, pop_en, flush;
  logic [PTR_W-1:0]      wr_ptr, rd_ptr;
  logic [SLOT_W-1:0]     wr_first;
  logic [3:0][SLOT_W-1:0] rd_slot;

  assign cfg.long_word = long_word_i;
  assign cfg.sec_en    = sec_en_i;
  // long words land upper half first
  assign wr_first = long_word_i ? bus_wdata_i[BUS_W-1:SLOT_W] : bus_wdata_i[SLOT_W-1:0];

  dtb_ctrl #(.SLOTS(SLOTS), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_size32_i(bus_size32_i),
    .frame_req_i(frame_req_i),
    .wr_en_o(wr_en), .wr_two_o(wr_two), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .pop_en_o(pop_en), .flush_o(flush), .level_o(level_o),
    .full_o(full_o), .empty_o(empty_o), .bus_err_o(bus_err_o),
    .size_err_o(size_err_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  dtb_storage #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .we_two_i(wr_two),
    .wr_ptr_i(wr_ptr), .wr_first_i(wr_first), .wr_second_i(bus_wdata_i[SLOT_W-1:0]),
    .rd_ptr_i(rd_ptr), .rd_slot_o(rd_slot)
  );

  dtb_unpack #(.SLOT_W(SLOT_W)) u_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .pop_en_i(pop_en), .cfg_i(cfg),
    .slot_i(rd_slot), .frame_valid_o(frame_valid_o),
    .pri_o(pri_data_o), .sec_o(sec_data_o)
  );
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker #(
  parameter int SLOTS = 8,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             long_word_i,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic             bus_size32_i,
  input logic             frame_req_i,
  input logic             flush_i,
  input logic [LVL_W-1:0] level_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             bus_err_o,
  input logic             size_err_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic             frame_valid_o
);
  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(SLOTS));
  assert_full_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_read_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_we_i |=> bus_err_o);
  assert_read_keeps_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_we_i && !frame_req_i && !flush_i |=> $stable(level_o));
  assert_size_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_we_i && !flush_i && (bus_size32_i != long_word_i) |=> size_err_o);
  assert_size_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |=> size_err_o);
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_req_i && !flush_i && empty_o |=> underflow_o && !frame_valid_o);
  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

bind dual_tx_buffer dtb_checker #(.SLOTS(SLOTS), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .long_word_i(long_word_i),
  .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_size32_i(bus_size32_i),
  .frame_req_i(frame_req_i), .flush_i(flush), .level_o(level_o),
  .full_o(full_o), .empty_o(empty_o), .bus_err_o(bus_err_o),
  .size_err_o(size_err_o), .overflow_o(overflow_o), .underflow_o(underflow_o),
  .frame_valid_o(frame_valid_o)
);

// File: tb/tb_dual_tx_buffer.sv
module tb_dual_tx_buffer;
  localparam int CLK_P = 10;
  localparam int SLOTS = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        long_w = 1'b0, sec_en = 1'b0;
  logic        req = 1'b0, we = 1'b0, sz32 = 1'b0, frame_req = 1'b0;
  logic [31:0] wdata = '0;
  logic        bus_err, fvalid, full, empty, size_err, ovf, udf;
  logic [31:0] pri, sec;
  logic [3:0]  level;

  int total = 0, bad = 0;
  logic [31:0] q[$];

  always #(CLK_P/2) clk = ~clk;

  dual_tx_buffer dut (
    .clk_i(clk), .rst_ni(rst_n), .long_word_i(long_w), .sec_en_i(sec_en),
    .bus_req_i(req), .bus_we_i(we), .bus_size32_i(sz32), .bus_wdata_i(wdata),
    .bus_err_o(bus_err), .frame_req_i(frame_req), .frame_valid_o(fvalid),
    .pri_data_o(pri), .sec_data_o(sec), .level_o(level), .full_o(full),
    .empty_o(empty), .size_err_o(size_err), .overflow_o(ovf), .underflow_o(udf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lw, input logic se);
    @(negedge clk);
    rst_n = 1'b0; long_w = lw; sec_en = se;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    q.delete();
  endtask

  task automatic bus_write(input logic [31:0] d, input logic s32);
    req = 1'b1; we = 1'b1; sz32 = s32; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read();
    req = 1'b1; we = 1'b0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic frame();
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'h1357_9bdf + 32'(k) * 32'h0101_1111;
  endfunction

  task automatic run_cfg(input logic lw, input logic se);
    int wneed, cap, fr;
    logic [31:0] ep, es, v;
    wneed = lw ? 2 : 1;
    cap   = SLOTS / wneed;
    fr    = se ? cap / 2 : cap;
    do_reset(lw, se);
    // R11 reset state
    chk("R11 level", 32'(level), 0);
    chk("R11 empty", 32'(empty), 1);
    chk("R11 flags", {27'd0, full, bus_err, size_err, ovf, udf}, 0);
    chk("R11 fvalid", 32'(fvalid), 0);
    // R9 underflow when empty
    frame();
    chk("R9 underflow empty", 32'(udf), 1);
    chk("R9 no frame", 32'(fvalid), 0);
    do_reset(lw, se);
    for (int i = 0; i < cap; i++) begin
      v = lw ? pat(i) : {16'h0, pat(i)[15:0]};
      bus_write(pat(i), lw);
      q.push_back(v);
      chk(lw ? "R2 level" : "R1 level", 32'(level), 32'((i + 1) * wneed));
      chk(lw ? "R2 full" : "R1 full", 32'(full), 32'(i == cap - 1));
    end
    chk("R2 not empty", 32'(empty), 0);
    // R8 overflow drops write
    bus_write(32'hdead_beef, lw);
    chk("R8 overflow", 32'(ovf), 1);
    chk("R8 level", 32'(level), SLOTS);
    // R7 wrong size
    bus_write(32'hcafe_f00d, !lw);
    chk("R7 size_err", 32'(size_err), 1);
    chk("R7 level", 32'(level), SLOTS);
    // R6 read error
    bus_read();
    chk("R6 bus_err", 32'(bus_err), 1);
    chk("R6 level", 32'(level), SLOTS);
    @(negedge clk);
    chk("R6 err pulse", 32'(bus_err), 0);
    for (int f = 0; f < fr; f++) begin
      ep = q.pop_front();
      es = se ? q.pop_front() : 32'h0;
      frame();
      chk("R3 fvalid", 32'(fvalid), 1);
      chk(se ? "R4 pri" : (lw ? "R5 pri" : "R3 pri"), pri, ep);
      chk(se ? "R4 sec" : "R3 sec", sec, es);
      chk("R5 level", 32'(level), 32'(SLOTS - (f + 1) * wneed * (se ? 2 : 1)));
    end
    chk("R2 empty", 32'(empty), 1);
    chk("R7 sticky", 32'(size_err), 1);
    chk("R8 sticky", 32'(ovf), 1);
    if (se) begin
      // half a frame present: R9
      bus_write(pat(40), lw);
      frame();
      chk("R9 partial udf", 32'(udf), 1);
      chk("R9 partial fvalid", 32'(fvalid), 0);
      chk("R9 partial level", 32'(level), 32'(wneed));
    end else begin
      bus_write(pat(40), lw);
    end
    // R10 flush on configuration change
    sec_en = !se;
    @(negedge clk);
    chk("R10 flush level", 32'(level), 0);
    chk("R10 flush empty", 32'(empty), 1);
    sec_en = se;
    @(negedge clk);
    bus_write(pat(50), lw);
    frame();
    if (!se) chk("R10 fresh data", pri, lw ? pat(50) : {16'h0, pat(50)[15:0]});
    else chk("R10 fresh udf", 32'(udf), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) run_cfg(c[1], c[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule